// File: doc/BRIEF.md
# Dual-Channel Double-Buffered TMS Serializer

This block drives the mode-select lines of two independent test-access scan chains. For each channel, the host writes bytes into a two-slot buffer. While one slot is being shifted out, the other can take the next byte. Bits leave the active slot least significant bit first, one per falling edge of the scan clock, and only while shifting is allowed. A 3-bit bit counter is shared by both channels and keeps them byte-aligned. When a byte has been fully sent, the active slot is released and the other slot takes over.

The scan-length counter sits outside the block. Its value and enable arrive as inputs. On the step that takes the counter from one to zero (terminal count), the active byte is released early. Its unsent bits are dropped and the bit counter restarts, so scan lengths need not be whole bytes.

An optional auto-high mode forces both lines to 1 while the counter reads one. This lets a chain leave its shift state on the final bit without the host loading a special pattern. A loop-back test input freezes the serial side completely. A high-impedance request turns off the pad drive enables and leaves the held data untouched.

Top module: `tms_dual_serializer`

## Requirements
- R1: After reset, both `tms_o` bits are 1, both `not_full` bits are 1 and both buffers are empty.
- R2: A write to a channel whose buffer holds fewer than two bytes is stored, whether or not that channel is enabled. A write to a full channel is dropped, and `not_full` for that channel is 0 while two bytes are held.
- R3: A channel shifts only when its `ch_en` bit is 1, its buffer is non-empty, `tck_en` is 1 and `loopback` is 0. Otherwise its `tms_o` bit and its buffer stay unchanged, unless R8 applies.
- R4: `tms_o` is a register updated on the falling edge of `sck`. Each shift sends one bit, bit 0 first. Bytes go out back-to-back in the order they were written.
- R5: The shared bit counter (values 0..7) advances on every falling edge with `tck_en`=1 and `loopback`=0, whether or not any channel shifts. A shifting channel sends bit[counter] of its active byte and releases that byte after sending bit 7.
- R6: When a shifting edge sees `cnt_en`=1 and `cnt_val`=1 (terminal count, the counter reaches zero), each shifting channel releases its active byte after the current bit and drops the rest of that byte. The bit counter returns to 0.
- R7: While `loopback` is 1, both outputs hold, no buffer is released, and the bit counter is frozen.
- R8: With `auto_high`=1 and `cnt_val`=1 and `loopback`=0, both `tms_o` bits load 1 at the falling edge. This applies to channels that are not shifting too. Buffers still advance as in R3 to R6.
- R9: `tms_oe` is 0 for both channels while `hiz` is 1, and 1 otherwise. `hiz` does not alter `tms_o`.
- R10: `not_full` shows, per channel, that fewer than two bytes are buffered. It rises again after a byte is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sck | input | 1 | Scan clock; all state changes on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| hiz | input | 1 | Request to float both lines (drive enables low) |
| wr_en | input | NCH | Per-channel host write strobe |
| wr_data | input | DW | Host byte, shared by both channels |
| ch_en | input | NCH | Per-channel shift enable |
| tck_en | input | 1 | Test clock enabled for this cycle |
| loopback | input | 1 | Loop-back test in progress; freezes serial side |
| cnt_en | input | 1 | Scan-length counter enabled |
| cnt_val | input | CW | Scan-length counter value |
| auto_high | input | 1 | Auto-high mode select |
| tms_o | output | NCH | Serial mode-select data per channel |
| tms_oe | output | NCH | Pad drive enable per channel |
| not_full | output | NCH | Buffer can accept a byte |

## Verification
Every cycle, the assertions check these points:
- the outputs hold under loop-back;
- both lines are high the cycle after auto-high sees a count of one;
- the lines hold while no test clock runs and auto-high is not active;
- `not_full` falls only on a write;
- `not_full` holds for a channel that is neither enabled nor written.

Only the directed scenarios can show the following:
- exact bit order across two bytes;
- that a third byte is truly dropped;
- mid-byte alignment after the shared counter ran with the channel disabled;
- that terminal count discards leftover bits and restarts at bit 0 of the next byte;
- that a frozen loop-back resumes on the right bit.

// File: rtl/tms_ser_pkg.sv
`timescale 1ns/1ps
package tms_ser_pkg;
  parameter int unsigned TMS_CHANNELS = 2;
  parameter int unsigned TMS_BYTE_W   = 8;
  parameter int unsigned TMS_LEN_W    = 32;
  localparam int unsigned TMS_SLOTS   = 2;
  localparam int unsigned TMS_OCC_W   = $clog2(TMS_SLOTS + 1);

  typedef enum logic [1:0] {
    SRC_HOLD   = 2'd0,
    SRC_FORCE1 = 2'd1,
    SRC_SHIFT  = 2'd2
  } tms_src_e;
endpackage

// File: rtl/tms_rst_sync.sv
`timescale 1ns/1ps
module tms_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/tms_bit_ctr.sv
`timescale 1ns/1ps
module tms_bit_ctr #(
  parameter int unsigned DW = 8,
  localparam int unsigned BW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          restart,
  output logic [BW-1:0] bit_idx,
  output logic          last_bit
);
  logic [BW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (restart)                  cnt_d = '0;
    else if (cnt_q == BW'(DW-1))  cnt_d = '0;
    else                          cnt_d = cnt_q + BW'(1);
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (step)  cnt_q <= cnt_d;
  end

  assign bit_idx  = cnt_q;
  assign last_bit = (cnt_q == BW'(DW-1));
endmodule

// File: rtl/tms_channel.sv
`timescale 1ns/1ps
module tms_channel
  import tms_ser_pkg::*;
#(
  parameter int unsigned DW = 8,
  localparam int unsigned BW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          ch_en,
  input  logic          step,
  input  logic [BW-1:0] bit_idx,
  input  logic          byte_end,
  input  logic          tc_step,
  input  logic          force_high,
  input  logic          hold,
  output logic          tms_q,
  output logic          not_full
);
  logic [TMS_SLOTS-1:0][DW-1:0] slot_q;
  logic [TMS_OCC_W-1:0]         occ_q, occ_d;
  logic                         wr_ptr_q, rd_ptr_q;
  logic                         tms_d;
  logic                         full, nonempty, wr_ok, shift, pop;
  tms_src_e                     src;

  assign full     = (occ_q == TMS_OCC_W'(TMS_SLOTS));
  assign nonempty = (occ_q != '0);
  assign wr_ok    = wr_en & ~full;
  assign shift    = ch_en & step & nonempty;
  assign pop      = shift & (byte_end | tc_step);

  always_comb begin
    occ_d = occ_q;
    if (wr_ok && !pop)      occ_d = occ_q + TMS_OCC_W'(1);
    else if (pop && !wr_ok) occ_d = occ_q - TMS_OCC_W'(1);
  end

  always_comb begin
    if (hold)            src = SRC_HOLD;
    else if (force_high) src = SRC_FORCE1;
    else if (shift)      src = SRC_SHIFT;
    else                 src = SRC_HOLD;
  end

  always_comb begin
    unique case (src)
      SRC_FORCE1: tms_d = 1'b1;
      SRC_SHIFT:  tms_d = slot_q[rd_ptr_q][bit_idx];
      default:    tms_d = tms_q;
    endcase
  end

  always_ff @(negedge clk) begin
    if (wr_ok) slot_q[wr_ptr_q] <= wr_data;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q    <= '0;
      wr_ptr_q <= 1'b0;
      rd_ptr_q <= 1'b0;
      tms_q    <= 1'b1;
    end else begin
      occ_q <= occ_d;
      if (wr_ok) wr_ptr_q <= ~wr_ptr_q;
      if (pop)   rd_ptr_q <= ~rd_ptr_q;
      tms_q <= tms_d;
    end
  end

  assign not_full = ~full;
endmodule

// File: rtl/tms_dual_serializer.sv
`timescale 1ns/1ps
module tms_dual_serializer
  import tms_ser_pkg::*;
#(
  parameter int unsigned NCH = TMS_CHANNELS,
  parameter int unsigned DW  = TMS_BYTE_W,
  parameter int unsigned CW  = TMS_LEN_W,
  localparam int unsigned BW = $clog2(DW)
) (
  input  logic           sck,
  input  logic           rst_n,
  input  logic           hiz,
  input  logic [NCH-1:0] wr_en,
  input  logic [DW-1:0]  wr_data,
  input  logic [NCH-1:0] ch_en,
  input  logic           tck_en,
  input  logic           loopback,
  input  logic           cnt_en,
  input  logic [CW-1:0]  cnt_val,
  input  logic           auto_high,
  output logic [NCH-1:0] tms_o,
  output logic [NCH-1:0] tms_oe,
  output logic [NCH-1:0] not_full
);
  logic          rst_sync_n;
  logic          step, at_one, tc_step, force_high;
  logic [BW-1:0] bit_idx;
  logic          last_bit;

  assign step       = tck_en & ~loopback;
  assign at_one     = (cnt_val == CW'(1));
  assign tc_step    = step & cnt_en & at_one;
  assign force_high = auto_high & at_one;

  tms_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (sck),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tms_bit_ctr #(.DW(DW)) i_bit_ctr (
    .clk      (sck),
    .rst_n    (rst_sync_n),
    .step     (step),
    .restart  (tc_step),
    .bit_idx  (bit_idx),
    .last_bit (last_bit)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    tms_channel #(.DW(DW)) i_channel (
      .clk        (sck),
      .rst_n      (rst_sync_n),
      .wr_en      (wr_en[g]),
      .wr_data    (wr_data),
      .ch_en      (ch_en[g]),
      .step       (step),
      .bit_idx    (bit_idx),
      .byte_end   (last_bit),
      .tc_step    (tc_step),
      .force_high (force_high),
      .hold       (loopback),
      .tms_q      (tms_o[g]),
      .not_full   (not_full[g])
    );
  end

  assign tms_oe = {NCH{~hiz}};
endmodule

// File: rtl/tms_dual_serializer_chk.sv
`timescale 1ns/1ps
module tms_dual_serializer_chk #(
  parameter int unsigned NCH = 2,
  parameter int unsigned CW  = 32
) (
  input logic           sck,
  input logic           rst_sync_n,
  input logic [NCH-1:0] wr_en,
  input logic [NCH-1:0] ch_en,
  input logic           tck_en,
  input logic           loopback,
  input logic [CW-1:0]  cnt_val,
  input logic           auto_high,
  input logic [NCH-1:0] tms_o,
  input logic [NCH-1:0] not_full
);
  // R7
  loopback_hold_chk: assert property (@(negedge sck) disable iff (!rst_sync_n)
    loopback |=> $stable(tms_o));

  // R8
  auto_high_chk: assert property (@(negedge sck) disable iff (!rst_sync_n)
    (auto_high && cnt_val == CW'(1) && !loopback) |=> (tms_o == {NCH{1'b1}}));

  // R3
  no_clock_hold_chk: assert property (@(negedge sck) disable iff (!rst_sync_n)
    (!tck_en && !(auto_high && cnt_val == CW'(1))) |=> $stable(tms_o));

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    // R2
    full_on_write_chk: assert property (@(negedge sck) disable iff (!rst_sync_n)
      $fell(not_full[g]) |-> $past(wr_en[g]));

    // R10
    idle_level_chk: assert property (@(negedge sck) disable iff (!rst_sync_n)
      (!ch_en[g] && !wr_en[g]) |=> $stable(not_full[g]));
  end
endmodule

bind tms_dual_serializer tms_dual_serializer_chk #(.NCH(NCH), .CW(CW)) i_chk (
  .sck        (sck),
  .rst_sync_n (rst_sync_n),
  .wr_en      (wr_en),
  .ch_en      (ch_en),
  .tck_en     (tck_en),
  .loopback   (loopback),
  .cnt_val    (cnt_val),
  .auto_high  (auto_high),
  .tms_o      (tms_o),
  .not_full   (not_full)
);

// File: tb/test_tms_dual_serializer.sv
`timescale 1ns/1ps
module test_tms_dual_serializer;
  localparam int NCH = 2;
  localparam int DW  = 8;
  localparam int CW  = 32;

  logic           sck = 1'b0;
  logic           rst_n;
  logic           hiz;
  logic [NCH-1:0] wr_en;
  logic [DW-1:0]  wr_data;
  logic [NCH-1:0] ch_en;
  logic           tck_en, loopback, cnt_en, auto_high;
  logic [CW-1:0]  cnt_val;
  logic [NCH-1:0] tms_o, tms_oe, not_full;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 sck = ~sck;

  tms_dual_serializer #(.NCH(NCH), .DW(DW), .CW(CW)) i_tms_dual_serializer (
    .sck(sck), .rst_n(rst_n), .hiz(hiz), .wr_en(wr_en), .wr_data(wr_data),
    .ch_en(ch_en), .tck_en(tck_en), .loopback(loopback), .cnt_en(cnt_en),
    .cnt_val(cnt_val), .auto_high(auto_high), .tms_o(tms_o), .tms_oe(tms_oe),
    .not_full(not_full)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // advance one clock; inputs change and outputs are read after the rising edge
  task automatic tick();
    @(posedge sck);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; hiz = 1'b0; wr_en = '0; wr_data = '0; ch_en = '0;
    tck_en = 1'b0; loopback = 1'b0; cnt_en = 1'b0; cnt_val = '0; auto_high = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
  endtask

  task automatic write_byte(input int ch, input logic [7:0] d);
    wr_en[ch] = 1'b1; wr_data = d;
    tick();
    wr_en = '0;
  endtask

  task automatic test_reset();
    do_reset();
    check("R1 tms after reset", 32'(tms_o), 32'h3);
    check("R1 not_full after reset", 32'(not_full), 32'h3);
    ch_en = '1; tck_en = 1'b1;
    repeat (3) tick();
    check("R1 empty buffers hold line", 32'(tms_o), 32'h3);
  endtask

  task automatic test_write_order();
    logic [15:0] stream;
    do_reset();
    write_byte(1, 8'h6A);
    check("R2 not_full after one write (disabled ch)", 32'(not_full[1]), 32'h1);
    write_byte(1, 8'h35);
    check("R10 not_full low when two held", 32'(not_full[1]), 32'h0);
    write_byte(1, 8'hFF);
    check("R2 dropped write keeps full", 32'(not_full[1]), 32'h0);
    stream = {8'h35, 8'h6A};
    ch_en[1] = 1'b1; tck_en = 1'b1;
    for (int i = 0; i < 16; i++) begin
      tick();
      check($sformatf("R4 ch1 bit %0d", i), 32'(tms_o[1]), 32'(stream[i]));
      if (i == 7) check("R5 byte released after bit 7", 32'(not_full[1]), 32'h1);
    end
    for (int i = 0; i < 4; i++) begin
      tick();
      check("R2 third byte never shifted", 32'(tms_o[1]), 32'h0);
    end
    check("R3 other channel untouched", 32'(tms_o[0]), 32'h1);
  endtask

  task automatic test_alignment();
    logic [7:0] d;
    do_reset();
    d = 8'hF7;
    write_byte(0, d);
    write_byte(0, 8'h00);
    tck_en = 1'b1;
    repeat (3) tick();
    check("R3 disabled channel holds", 32'(tms_o[0]), 32'h1);
    check("R3 disabled channel keeps buffer", 32'(not_full[0]), 32'h0);
    ch_en[0] = 1'b1;
    for (int b = 3; b < 8; b++) begin
      tick();
      check($sformatf("R5 shared counter bit %0d", b), 32'(tms_o[0]), 32'(d[b]));
    end
    check("R5 release after bit 7", 32'(not_full[0]), 32'h1);
    tick();
    check("R5 next byte starts at bit 0", 32'(tms_o[0]), 32'h0);
  endtask

  task automatic test_terminal_count();
    do_reset();
    write_byte(0, 8'h07);
    write_byte(0, 8'h01);
    ch_en[0] = 1'b1; tck_en = 1'b1; cnt_en = 1'b1;
    for (int c = 3; c >= 1; c--) begin
      cnt_val = CW'(c);
      tick();
      check($sformatf("R6 bit at count %0d", c), 32'(tms_o[0]), 32'h1);
    end
    check("R6 byte released at terminal count", 32'(not_full[0]), 32'h1);
    cnt_val = '0; cnt_en = 1'b0;
    tick();
    check("R6 leftover dropped, next byte bit 0", 32'(tms_o[0]), 32'h1);
    tick();
    check("R6 next byte bit 1", 32'(tms_o[0]), 32'h0);
  endtask

  task automatic test_auto_high();
    for (int mode = 1; mode >= 0; mode--) begin
      do_reset();
      write_byte(0, 8'h00);
      write_byte(1, 8'h00);
      ch_en = '1; tck_en = 1'b1; cnt_en = 1'b1; auto_high = mode[0];
      cnt_val = CW'(3); tick();
      check("R8 low before last count", 32'(tms_o), 32'h0);
      cnt_val = CW'(2); tick();
      cnt_val = CW'(1); tick();
      check($sformatf("R8 last bit auto_high=%0d", mode), 32'(tms_o), mode ? 32'h3 : 32'h0);
      check("R8 buffers advanced", 32'(not_full), 32'h3);
    end
    do_reset();
    write_byte(0, 8'h00);
    ch_en[0] = 1'b1; tck_en = 1'b1; tick();
    tck_en = 1'b0; ch_en = '0; auto_high = 1'b1; cnt_val = CW'(1);
    tick();
    check("R8 forces idle channel too", 32'(tms_o), 32'h3);
  endtask

  task automatic test_loopback();
    do_reset();
    write_byte(0, 8'h02);
    ch_en[0] = 1'b1; tck_en = 1'b1;
    tick();
    check("R4 first bit", 32'(tms_o[0]), 32'h0);
    loopback = 1'b1;
    repeat (4) tick();
    check("R7 output held", 32'(tms_o[0]), 32'h0);
    auto_high = 1'b1; cnt_val = CW'(1);
    tick();
    check("R7 held over auto-high", 32'(tms_o[0]), 32'h0);
    auto_high = 1'b0; cnt_val = '0; loopback = 1'b0;
    tick();
    check("R7 counter frozen, resumes bit 1", 32'(tms_o[0]), 32'h1);
  endtask

  task automatic test_hiz();
    do_reset();
    write_byte(0, 8'h00);
    ch_en[0] = 1'b1; tck_en = 1'b1; tick();
    tck_en = 1'b0;
    hiz = 1'b1; #1;
    check("R9 drive off", 32'(tms_oe), 32'h0);
    tick();
    check("R9 data kept", 32'(tms_o), 32'h2);
    hiz = 1'b0; #1;
    check("R9 drive on", 32'(tms_oe), 32'h3);
  endtask

  initial begin
    #500000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    test_reset();
    test_write_order();
    test_alignment();
    test_terminal_count();
    test_auto_high();
    test_loopback();
    test_hiz();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule